// File: doc/BRIEF.md
# Ping-pong receive buffer

This block takes received Ethernet frames as a byte stream and parks each whole frame in a receive bank that software reads through a memory-mapped window. The stream has three signals: a valid strobe, a data byte and an end-of-frame marker. There are one or two banks, set by a parameter. With two banks, consecutive frames go to alternate banks, so software can drain one bank while the next frame lands in the other.

When the final byte of a frame is stored, the bank's done flag is raised. If both the bank's own enable and the global enable are set, a one-cycle interrupt pulse is also produced. Software reads the frame words and then clears the done flag to hand the bank back. A frame that arrives for a bank still holding an unreleased frame is discarded in full.

The window is 13 bits of byte address.
- Bank 0 starts at 0x1000 and bank 1 at 0x1800.
- Each bank's status word sits 0x7FC above its base.
- The global enable is at 0x7F8.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, every done flag, bank enable and the global enable read as 0, `irq` is low, and the first frame goes to bank 0.
- R2: Frame bytes are packed four to a 32-bit word from the bank base upward. The first byte of each group of four lands in bits 7:0 and the fourth in bits 31:24. Bytes past the end of the frame in its final word read as 0.
- R3: Bit 0 of a bank's status word (base + 0x7FC) reads 1 from the cycle after the frame's last byte is accepted into that bank.
- R4: A status write with bit 0 at 0 clears that bank's done flag. A write with bit 0 at 1 leaves it unchanged. Nothing else clears it.
- R5: With two banks, accepted frames alternate 0, 1, 0, 1. A discarded frame does not advance the alternation.
- R6: A frame whose target bank still has its done flag set is discarded whole. The bank contents, both done flags and `irq` are left unchanged.
- R7: A frame longer than DATA_WORDS*4 bytes keeps only its first DATA_WORDS*4 bytes, and its done flag is still set. Data words at index DATA_WORDS and above read as 0.
- R8: `irq` pulses high for one cycle, in the same cycle that a done flag first reads 1. It pulses only if that bank's enable (status bit 3) and the global enable (bit 31 at 0x7F8) were both set. Otherwise it stays low.
- R9: With one bank, every frame targets bank 0, and the bank 1 window reads 0 and ignores writes.
- R10: Status bit 3 and global bit 31 read back as written, with all other status and global bits reading 0. Accesses whose address bits 1:0 are not zero are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 13 | Byte address into the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Frame-received interrupt pulse |

## Verification
The hardest state to reach is the one where both banks hold unreleased frames, so that a further frame is discarded. Reaching it takes two accepted frames in alternate banks with no release in between. It must then be confirmed that the discarded frame did not disturb the stored data or shift the alternation. The directed part of the stimulus builds this state on purpose, and also fills both banks with over-long frames so that every data word is defined before checks begin. The random part then mixes frame lengths with random releases and enable changes, so that discards, truncation and gated interrupts keep recurring. A one-bank instance shares the same stimulus, which means it sees discards far more often.

// File: rtl/rx_pingpong_buf.sv
`timescale 1ns/1ps
module rx_pingpong_buf #(
  parameter int NUM_BANKS  = 2,
  parameter int DATA_WORDS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [12:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int WIDX_W = $clog2(DATA_WORDS);
  localparam logic [WIDX_W:0] CAP = (WIDX_W+1)'(DATA_WORDS);
  localparam logic [8:0] STAT_IDX = 9'h1FF;
  localparam logic [8:0] GIE_IDX  = 9'h1FE;

  logic in_frame, drop_q, tgt_q, cur_q, gie_q, irq_q;
  logic [1:0] done_q, ie_q;
  logic [1:0] lane_q;
  logic [WIDX_W:0] wcnt_q;
  logic [23:0] pack_q;
  logic [31:0] word_new, rd_next;
  logic [31:0] rd_word [2];

  logic sof, tgt_now, drop_now, store, word_we, fin_ok;
  assign sof      = in_valid && !in_frame;
  assign tgt_now  = sof ? cur_q : tgt_q;
  assign drop_now = sof ? done_q[cur_q] : drop_q;
  assign store    = in_valid && !drop_now && (wcnt_q < CAP);
  assign word_we  = store && (lane_q == 2'd3 || in_last);
  assign fin_ok   = in_valid && in_last && !drop_now;

  always_comb begin
    case (lane_q)
      2'd0:    word_new = {24'b0, in_data};
      2'd1:    word_new = {16'b0, in_data, pack_q[7:0]};
      2'd2:    word_new = {8'b0, in_data, pack_q[15:0]};
      default: word_new = {in_data, pack_q};
    endcase
  end

  logic [8:0] aidx;
  logic rx_win, bsel, bank_ok, aligned, is_stat, is_gie, in_rng;
  assign aidx    = bus_addr[10:2];
  assign rx_win  = bus_addr[12];
  assign bsel    = bus_addr[11];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign bank_ok = (NUM_BANKS == 2) || !bsel;
  assign is_stat = aligned && rx_win && bank_ok && (aidx == STAT_IDX);
  assign is_gie  = aligned && !rx_win && !bsel && (aidx == GIE_IDX);
  assign in_rng  = aligned && rx_win && bank_ok && ({1'b0, aidx} < 10'(DATA_WORDS));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      logic [31:0] mem [DATA_WORDS];
      always_ff @(posedge clk)
        if (word_we && tgt_now == 1'(b)) mem[wcnt_q[WIDX_W-1:0]] <= word_new;
      assign rd_word[b] = mem[aidx[WIDX_W-1:0]];
    end else begin : g_off
      assign rd_word[b] = '0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_gie) rd_next[31] = gie_q;
    else if (is_stat) begin
      rd_next[3] = ie_q[bsel];
      rd_next[0] = done_q[bsel];
    end else if (in_rng) rd_next = rd_word[bsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      drop_q    <= 1'b0;
      tgt_q     <= 1'b0;
      cur_q     <= 1'b0;
      gie_q     <= 1'b0;
      irq_q     <= 1'b0;
      done_q    <= '0;
      ie_q      <= '0;
      lane_q    <= '0;
      wcnt_q    <= '0;
      pack_q    <= '0;
      bus_rdata <= '0;
    end else begin
      irq_q <= fin_ok && ie_q[tgt_now] && gie_q;
      if (in_valid) begin
        tgt_q  <= tgt_now;
        drop_q <= drop_now;
        if (in_last) begin
          in_frame <= 1'b0;
          lane_q   <= '0;
          wcnt_q   <= '0;
        end else begin
          in_frame <= 1'b1;
          lane_q   <= lane_q + 2'd1;
          if (lane_q == 2'd3 && wcnt_q < CAP) wcnt_q <= wcnt_q + 1'b1;
        end
        if (store) pack_q <= word_new[23:0];
      end
      if (bus_wr && is_stat) begin
        ie_q[bsel] <= bus_wdata[3];
        if (!bus_wdata[0]) done_q[bsel] <= 1'b0;
      end
      if (bus_wr && is_gie) gie_q <= bus_wdata[31];
      if (fin_ok) begin
        done_q[tgt_now] <= 1'b1;
        cur_q <= (NUM_BANKS == 2) ? !tgt_now : 1'b0;
      end
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

  assign irq = irq_q;

  AST_DONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q[0]) |-> $past(in_valid && in_last)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q[0] && !(bus_wr && is_stat && !bsel && !bus_wdata[0]) |=> done_q[0]); // R4
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($rose(done_q[0]) || $rose(done_q[1]))); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(gie_q)); // R8
endmodule

// File: tb/rx_pingpong_buf_bench.sv
`timescale 1ns/1ps
module rx_pingpong_buf_bench;
  localparam int DW = 128;
  localparam int CAPB = DW * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic irq0, irq1;

  rx_pingpong_buf #(.NUM_BANKS(2), .DATA_WORDS(DW)) u_rx_pingpong_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata0), .irq(irq0));

  rx_pingpong_buf #(.NUM_BANKS(1), .DATA_WORDS(DW)) u_rx_pingpong_buf_one (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1), .irq(irq1));

  int checks = 0, errors = 0;
  logic [7:0] frm [600];
  logic [31:0] e_mem [2][2][DW];
  bit e_val [2][2][DW];
  bit e_done [2][2];
  bit e_ie [2][2];
  bit e_gie [2];
  bit e_cur [2];
  int irqc [2];
  bit counting = 1'b0;

  always @(negedge clk) if (counting) begin
    irqc[0] += int'(irq0);
    irqc[1] += int'(irq1);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ew(input int w, input int len);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++)
      if (4 * w + j < len) r[8*j +: 8] = frm[4 * w + j];
    return r;
  endfunction

  function automatic logic [31:0] e_stat(input int k, input int b);
    return {28'b0, e_ie[k][b], 2'b0, e_done[k][b]};
  endfunction

  task automatic rd(input logic [12:0] a, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    v0 = rdata0; v1 = rdata1;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (a == 13'h07F8) e_gie[k] = d[31];
      else if (a[12] && a[10:0] == 11'h7FC) begin
        if (k == 0 || !a[11]) begin
          e_ie[k][a[11]] = d[3];
          if (!d[0]) e_done[k][a[11]] = 1'b0;
        end
      end
    end
  endtask

  task automatic chk_status(input string req);
    logic [31:0] v0, v1;
    for (int b = 0; b < 2; b++) begin
      rd(13'h17FC | 13'(b << 11), v0, v1);
      chk(v0 === e_stat(0, b), req, v0, e_stat(0, b));
      chk(v1 === e_stat(1, b), {req, " one-bank"}, v1, e_stat(1, b));
    end
  endtask

  task automatic chk_content(input int nw, input string req);
    logic [31:0] v0, v1;
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < nw && w < DW; w++) begin
        rd(13'h1000 | 13'(b << 11) | 13'(w << 2), v0, v1);
        if (e_val[0][b][w]) chk(v0 === e_mem[0][b][w], req, v0, e_mem[0][b][w]);
        if (e_val[1][b][w]) chk(v1 === e_mem[1][b][w], {req, " one-bank"}, v1, e_mem[1][b][w]);
      end
  endtask

  task automatic send(input int len, input string req);
    bit acc [2];
    bit tg [2];
    int nw;
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    for (int k = 0; k < 2; k++) begin
      tg[k] = e_cur[k];
      acc[k] = !e_done[k][tg[k]];
      irqc[k] = 0;
    end
    counting = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = frm[i]; in_last = (i == len - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk); @(negedge clk); counting = 1'b0;
    nw = (len + 3) / 4;
    if (nw > DW) nw = DW;
    for (int k = 0; k < 2; k++) begin
      chk(irqc[k] == ((acc[k] && e_ie[k][tg[k]] && e_gie[k]) ? 1 : 0), {"R8 irq pulses ", req},
          32'(irqc[k]), (acc[k] && e_ie[k][tg[k]] && e_gie[k]) ? 32'd1 : 32'd0);
      if (acc[k]) begin
        for (int w = 0; w < nw; w++) begin
          e_mem[k][tg[k]][w] = ew(w, len);
          e_val[k][tg[k]][w] = 1'b1;
        end
        e_done[k][tg[k]] = 1'b1;
        if (k == 0) e_cur[0] = !tg[0];
      end
    end
    chk_status({"R3 R5 status ", req});
    chk_content(nw, {"R2 R6 content ", req});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    void'($urandom(32'd4711));
    for (int k = 0; k < 2; k++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < DW; w++) begin
          e_mem[k][b][w] = '0;
          e_val[k][b][w] = (k == 1 && b == 1);
        end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq0 === 1'b0 && irq1 === 1'b0, "R1 irq low after reset", {30'b0, irq1, irq0}, 32'd0);
    chk_status("R1 reset status");
    rd(13'h07F8, v0, v1);
    chk(v0 === 32'd0 && v1 === 32'd0, "R1 global enable reset", v0 | v1, 32'd0);

    wr(13'h07F8, 32'hFFFF_FFFF);
    rd(13'h07F8, v0, v1);
    chk(v0 === 32'h8000_0000 && v1 === 32'h8000_0000, "R10 global readback", v0 ^ v1 ^ v0, 32'h8000_0000);
    wr(13'h17FC, 32'h0000_FFF6);
    wr(13'h1FFC, 32'h0000_0008);
    chk_status("R10 status readback");

    send(CAPB + 8, "R7 long frame bank 0");
    rd(13'h1000 | 13'(DW << 2), v0, v1);
    chk(v0 === 32'd0 && v1 === 32'd0, "R7 word past capacity", v0 | v1, 32'd0);
    send(CAPB + 3, "R5 R9 long frame bank 1");
    send(7, "R6 both banks busy");

    wr(13'h17FD, 32'h0);
    chk_status("R10 unaligned write ignored");
    wr(13'h17FC, 32'h9);
    chk_status("R4 write one keeps done");
    wr(13'h17FC, 32'h8);
    chk_status("R4 write zero clears done");
    send(5, "R5 back to bank 0");
    send(1, "R2 single byte frame");

    wr(13'h07F8, 32'h0);
    wr(13'h1FFC, 32'h8);
    send(9, "R8 global enable off");
    wr(13'h07F8, 32'h8000_0000);
    wr(13'h17FC, 32'h0);
    send(6, "R8 bank enable off");

    for (int it = 0; it < 40; it++) begin
      if ($urandom % 2) wr(13'h17FC, {28'b0, 1'($urandom), 3'b0});
      if ($urandom % 2) wr(13'h1FFC, {28'b0, 1'($urandom), 3'b0});
      if ($urandom % 5 == 0) wr(13'h07F8, {1'($urandom), 31'b0});
      send(1 + int'($urandom % 70), "random frame");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule